// File: doc/BRIEF.md
# SCSI Command Execution Sequencer

This block holds the controller's command word and executes it on each sequencer tick. Three commands are acted on: disconnect, select, and programmed-I/O transfer. It keeps the link state in a small state machine with three states: `LINK_FREE`, `LINK_SELECTING` and `LINK_CONNECTED`. It also runs a modulo-8 phase counter that forms the low bits of the data status. The status registers are kept outside the block. The block sends them one-cycle set and clear strobes. When a programmed transfer completes, it issues a byte-transmit strobe that carries the data register byte.

Within one tick the work is done in a fixed order:
1. The target response.
2. Disconnect.
3. Select.
4. The transfer check.

Each step sees the link state left by the one before it. The link state machine has these transitions:
- `LINK_FREE` goes to `LINK_SELECTING` on select.
- `LINK_SELECTING` goes to `LINK_CONNECTED` on a target response.
- `LINK_SELECTING` goes to `LINK_FREE` on disconnect.
- `LINK_CONNECTED` goes to `LINK_FREE` on disconnect.
- `LINK_CONNECTED` goes to `LINK_SELECTING` on select.

A select in the same tick overrides a disconnect or a response.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After reset the command word is 0, the phase counter is 0, the link state is `LINK_FREE` (linked=0, selecting=0, link_id=0) and every strobe is low.
- R2: A cycle with `cmd_wr` high loads `cmd_wdata` into the command word with bit 14 (reset request) forced to 0. Bit 10 is stored and has no effect. No command is evaluated in a write cycle, even when `tick` is high.
- R3: Each cycle with `tick` high advances `dstat_cnt` by 1, wrapping from 7 to 0. Without `tick`, the counter holds.
- R4: Disconnect (bit 9) strobes clear-connected and clear-selection. It strobes state-change only if the link was connected at that point in the tick. It returns the link to `LINK_FREE` and clears bit 9.
- R5: Select (bit 8) clears bit 8 and strobes set-selection and clear-connected. It enters `LINK_SELECTING` and zeroes `link_id`.
- R6: A tick with `tgt_resp` high in `LINK_SELECTING` enters `LINK_CONNECTED`. It loads `link_id` from `tgt_id` and strobes set-connected, state-change and clear-selection. In other states `tgt_resp` is ignored.
- R7: Transfer (bit 7) proceeds only when all three hold: command bits 6:4 equal `bus_phase`, command bits 1:0 equal `dstat_cnt[1:0]` as it was before the tick, and the link is not selecting after the earlier steps of that tick.
- R8: A proceeding transfer with bit 12 clear pulses `pio_tx` with `pio_byte` equal to `pio_data`. It strobes transmit-buffer-empty and clears bit 7.
- R9: A transfer with bit 12 (DMA) set stays pending: bit 7 stays set and no `pio_tx` or transmit-buffer-empty is produced.
- R10: Within a tick, select followed by transfer blocks the transfer. A disconnect issued while selecting lets a transfer in the same word proceed.
- R11: All strobes are registered, one cycle wide, and appear in the cycle after the tick that caused them. There are none without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sequencer evaluation pulse |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word to write |
| bus_phase | input | 3 | Connection status phase bits |
| pio_data | input | DATA_W | Data register byte |
| tgt_resp | input | 1 | Target answered the selection |
| tgt_id | input | ID_W | ID of the responding target |
| cmd_q | output | 16 | Current command word |
| dstat_cnt | output | CNT_W | Free-running phase counter |
| linked | output | 1 | Link state is connected |
| selecting | output | 1 | Link state is selecting |
| link_id | output | ID_W | ID of the connected target |
| st_set_con | output | 1 | Set connected status |
| st_clr_con | output | 1 | Clear connected status |
| st_set_sip | output | 1 | Set selection-in-progress status |
| st_clr_sip | output | 1 | Clear selection-in-progress status |
| st_set_sch | output | 1 | Set state-change status |
| st_set_tbe | output | 1 | Set transmit-buffer-empty status |
| pio_tx | output | 1 | Programmed byte transmit strobe |
| pio_byte | output | DATA_W | Byte carried by `pio_tx` |

## Verification
The assertions assume that `tick` and `cmd_wr` are clean synchronous levels. They also assume that `tgt_resp` is meaningful only on tick cycles, and that a transfer is never written with DMA and programmed mode at once in one pending word. The stimulus changes inputs only on the falling edge. It raises `tgt_resp` only around a single tick, and it sweeps every command phase, bus phase and data-phase pair while the link is free, so that no selection can mask a transfer.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;
    localparam int CMD_W   = 16;
    localparam int B_XFER  = 7;
    localparam int B_SEL   = 8;
    localparam int B_DISC  = 9;
    localparam int B_DMA   = 12;
    localparam int B_RST   = 14;
    localparam int PH_LO   = 4;
    localparam int PH_HI   = 6;
    localparam int PH_W    = PH_HI - PH_LO + 1;
    localparam int DP_W    = 2;

    typedef enum logic [1:0] {
        LINK_FREE      = 2'd0,
        LINK_SELECTING = 2'd1,
        LINK_CONNECTED = 2'd2
    } link_e;

    typedef struct packed {
        logic set_con;
        logic clr_con;
        logic set_sip;
        logic clr_sip;
        logic set_sch;
        logic set_tbe;
    } stat_strb_t;
endpackage

// File: rtl/seq_phase_ctr.sv
module seq_phase_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/seq_cmd_reg.sv
module seq_cmd_reg
    import scsi_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CMD_W-1:0] wdata,
    input  logic [CMD_W-1:0] clr_mask,
    output logic [CMD_W-1:0] q
);
    localparam logic [CMD_W-1:0] RST_MASK = CMD_W'(1) << B_RST;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata & ~RST_MASK;
        end else begin
            q <= q & ~clr_mask;
        end
    end
endmodule

// File: rtl/seq_link_fsm.sv
module seq_link_fsm
    import scsi_seq_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            resp_go,
    input  logic            disc_go,
    input  logic            sel_go,
    input  logic [ID_W-1:0] tgt_id,
    output link_e           state,
    output logic            linked,
    output logic            selecting,
    output logic [ID_W-1:0] link_id
);
    link_e state_nx;
    logic [ID_W-1:0] id_nx;

    // Order inside one tick: response, disconnect, select.
    always_comb begin
        state_nx = state;
        id_nx    = link_id;
        unique case (state)
            LINK_FREE: begin
                if (sel_go) state_nx = LINK_SELECTING;
            end
            LINK_SELECTING: begin
                if (resp_go) begin
                    state_nx = LINK_CONNECTED;
                    id_nx    = tgt_id;
                end
                if (disc_go) state_nx = LINK_FREE;
                if (sel_go)  state_nx = LINK_SELECTING;
            end
            LINK_CONNECTED: begin
                if (disc_go) state_nx = LINK_FREE;
                if (sel_go)  state_nx = LINK_SELECTING;
            end
            default: state_nx = LINK_FREE;
        endcase
        if (sel_go) id_nx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= LINK_FREE;
            link_id <= '0;
        end else begin
            state   <= state_nx;
            link_id <= id_nx;
        end
    end

    always_comb begin
        linked    = 1'b0;
        selecting = 1'b0;
        unique case (state)
            LINK_FREE:      ;
            LINK_SELECTING: selecting = 1'b1;
            LINK_CONNECTED: linked    = 1'b1;
            default:        ;
        endcase
    end
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
    import scsi_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ID_W   = 3,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_wr,
    input  logic [15:0]       cmd_wdata,
    input  logic [2:0]        bus_phase,
    input  logic [DATA_W-1:0] pio_data,
    input  logic              tgt_resp,
    input  logic [ID_W-1:0]   tgt_id,
    output logic [15:0]       cmd_q,
    output logic [CNT_W-1:0]  dstat_cnt,
    output logic              linked,
    output logic              selecting,
    output logic [ID_W-1:0]   link_id,
    output logic              st_set_con,
    output logic              st_clr_con,
    output logic              st_set_sip,
    output logic              st_clr_sip,
    output logic              st_set_sch,
    output logic              st_set_tbe,
    output logic              pio_tx,
    output logic [DATA_W-1:0] pio_byte
);
    link_e            state;
    logic             ev, resp_go, disc_go, sel_go, xfer_go, pio_go;
    logic             con_mid, sip_final, phase_ok;
    logic [CMD_W-1:0] clr_mask;
    stat_strb_t       strb_nx, strb_q;
    logic             pio_q;
    logic [DATA_W-1:0] byte_q;

    seq_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cmd_wr),
        .wdata    (cmd_wdata),
        .clr_mask (clr_mask),
        .q        (cmd_q)
    );

    seq_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tick),
        .cnt   (dstat_cnt)
    );

    seq_link_fsm #(.ID_W(ID_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .resp_go   (resp_go),
        .disc_go   (disc_go),
        .sel_go    (sel_go),
        .tgt_id    (tgt_id),
        .state     (state),
        .linked    (linked),
        .selecting (selecting),
        .link_id   (link_id)
    );

    // Command decode, evaluated in the fixed per-tick order.
    always_comb begin
        ev       = tick & ~cmd_wr;
        resp_go  = ev & tgt_resp & (state == LINK_SELECTING);
        disc_go  = ev & cmd_q[B_DISC];
        sel_go   = ev & cmd_q[B_SEL];
        con_mid  = (state == LINK_CONNECTED) | resp_go;
        if (sel_go)                  sip_final = 1'b1;
        else if (disc_go | resp_go)  sip_final = 1'b0;
        else                         sip_final = (state == LINK_SELECTING);
        phase_ok = (cmd_q[PH_HI:PH_LO] == bus_phase)
                 & (cmd_q[DP_W-1:0] == dstat_cnt[DP_W-1:0]);
        xfer_go  = ev & cmd_q[B_XFER] & phase_ok & ~sip_final;
        pio_go   = xfer_go & ~cmd_q[B_DMA];

        clr_mask         = '0;
        clr_mask[B_DISC] = disc_go;
        clr_mask[B_SEL]  = sel_go;
        clr_mask[B_XFER] = pio_go;

        strb_nx.set_con = resp_go & ~disc_go & ~sel_go;
        strb_nx.clr_con = disc_go | sel_go;
        strb_nx.set_sip = sel_go;
        strb_nx.clr_sip = (disc_go | resp_go) & ~sel_go;
        strb_nx.set_sch = resp_go | (disc_go & con_mid);
        strb_nx.set_tbe = pio_go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= '0;
            pio_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            strb_q <= strb_nx;
            pio_q  <= pio_go;
            if (pio_go) byte_q <= pio_data;
        end
    end

    always_comb begin
        st_set_con = strb_q.set_con;
        st_clr_con = strb_q.clr_con;
        st_set_sip = strb_q.set_sip;
        st_clr_sip = strb_q.clr_sip;
        st_set_sch = strb_q.set_sch;
        st_set_tbe = strb_q.set_tbe;
        pio_tx     = pio_q;
        pio_byte   = byte_q;
    end
endmodule

// File: rtl/scsi_cmd_seq_chk.sv
module scsi_cmd_seq_chk #(
    parameter int ID_W  = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cmd_wr,
    input logic [15:0]      cmd_q,
    input logic [CNT_W-1:0] dstat_cnt,
    input logic             linked,
    input logic             selecting,
    input logic             st_set_con,
    input logic             st_clr_con,
    input logic             st_set_sip,
    input logic             st_clr_sip,
    input logic             st_set_sch,
    input logic             st_set_tbe,
    input logic             pio_tx
);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> dstat_cnt == CNT_W'($past(dstat_cnt) + 1'b1));

    a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dstat_cnt));

    a_r11_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !(st_set_con | st_clr_con | st_set_sip | st_clr_sip
                    | st_set_sch | st_set_tbe | pio_tx));

    a_r2_rst_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[14] == 1'b0);

    a_r8_tx_sets_tbe: assert property (@(posedge clk) disable iff (!rst_n)
        pio_tx |-> st_set_tbe);

    a_r9_dma_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick & !cmd_wr & cmd_q[12]) |=> !pio_tx);

    a_r5_select_state: assert property (@(posedge clk) disable iff (!rst_n)
        st_set_sip |-> selecting & !linked);

    a_r6_connect_state: assert property (@(posedge clk) disable iff (!rst_n)
        st_set_con |-> linked & !selecting);

    a_r4_linkstate_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(linked & selecting));
endmodule

bind scsi_cmd_seq scsi_cmd_seq_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/scsi_cmd_seq_tb.sv
module scsi_cmd_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cmd_wr = 1'b0, tgt_resp = 1'b0;
    logic [15:0] cmd_wdata = '0;
    logic [2:0]  bus_phase = 3'd5;
    logic [7:0]  pio_data = 8'h00;
    logic [2:0]  tgt_id = 3'd0;
    logic [15:0] cmd_q;
    logic [2:0]  dstat_cnt, link_id;
    logic        linked, selecting, pio_tx;
    logic        st_set_con, st_clr_con, st_set_sip, st_clr_sip, st_set_sch, st_set_tbe;
    logic [7:0]  pio_byte;

    int checks = 0, errors = 0;
    logic [2:0] cnt_m = 3'd0;
    bit done = 1'b0;

    localparam logic [15:0] XF = 16'h0080, SL = 16'h0100, DC = 16'h0200, DM = 16'h1000;

    always #4 clk = ~clk;

    scsi_cmd_seq u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic t, input logic w, input logic [15:0] d);
        tick = t; cmd_wr = w; cmd_wdata = d;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0; cmd_wr = 1'b0;
        if (t) cnt_m = cnt_m + 3'd1;
    endtask

    function automatic logic [15:0] mk_x(input logic dma);
        return XF | (dma ? DM : 16'h0) | (16'(bus_phase) << 4) | 16'(cnt_m[1:0]);
    endfunction

    function automatic logic [5:0] strb();
        return {st_set_con, st_clr_con, st_set_sip, st_clr_sip, st_set_sch, st_set_tbe};
    endfunction

    initial begin
        logic [15:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd", cmd_q, 0);
        chk("R1 cnt", dstat_cnt, 0);
        chk("R1 link", {linked, selecting, link_id}, 0);
        chk("R1 strobes", {strb(), pio_tx}, 0);

        step(0, 1, 16'h4400);
        chk("R2 reset bit dropped", cmd_q, 16'h0400);
        step(1, 0, 0);
        chk("R2 bit10 no effect", {strb(), pio_tx, linked, selecting}, 0);
        chk("R3 count", dstat_cnt, cnt_m);
        step(0, 1, 0);

        tgt_resp = 1'b1; tgt_id = 3'd6;
        step(1, 0, 0);
        tgt_resp = 1'b0;
        chk("R6 resp ignored when free", {linked, st_set_con, link_id}, 0);

        step(0, 1, DC);
        step(1, 0, 0);
        chk("R4 disc free strobes", strb(), 6'b010100);
        chk("R4 disc bit cleared", cmd_q[9], 0);

        step(0, 1, SL);
        step(1, 0, 0);
        chk("R5 select strobes", strb(), 6'b011000);
        chk("R5 selecting", {selecting, linked, link_id}, 5'b10000);
        chk("R5 bit cleared", cmd_q, 0);

        w = mk_x(0);
        step(0, 1, w);
        step(1, 0, 0);
        chk("R7 blocked while selecting", {pio_tx, st_set_tbe}, 0);
        chk("R7 still pending", cmd_q, w);
        step(0, 1, 0);

        tgt_resp = 1'b1; tgt_id = 3'd5;
        step(1, 0, 0);
        tgt_resp = 1'b0;
        chk("R6 connect strobes", strb(), 6'b100110);
        chk("R6 linked", {linked, selecting, link_id}, 5'b10101);

        step(0, 0, 0);
        chk("R11 no tick no strobe", {strb(), pio_tx}, 0);
        chk("R3 hold", dstat_cnt, cnt_m);

        step(0, 1, DC);
        step(1, 0, 0);
        chk("R4 disc connected sch", strb(), 6'b010110);
        chk("R4 free", {linked, selecting}, 0);

        w = mk_x(1);
        step(0, 1, w);
        step(1, 0, 0);
        chk("R9 dma pending", {pio_tx, st_set_tbe}, 0);
        chk("R9 dma bit kept", cmd_q, w);

        w = mk_x(0) | SL;
        step(0, 1, w);
        step(1, 0, 0);
        chk("R10 select blocks xfer", {pio_tx, st_set_sip}, 2'b01);
        chk("R10 xfer left", cmd_q, w & ~SL);

        pio_data = 8'hA7;
        w = mk_x(0) | DC;
        step(0, 1, w);
        step(1, 0, 0);
        chk("R10 disc unblocks xfer", {pio_tx, st_set_tbe, st_clr_sip}, 3'b111);
        chk("R8 byte", pio_byte, 8'hA7);
        chk("R8 bit7 cleared", cmd_q, w & ~(DC | XF));

        w = mk_x(0);
        step(1, 1, w);
        chk("R2 write tick no eval", {pio_tx, cmd_q}, {1'b0, w});
        chk("R3 count on write tick", dstat_cnt, cnt_m);

        for (int cp = 0; cp < 8; cp++) begin
            for (int bp = 0; bp < 8; bp++) begin
                for (int dp = 0; dp < 4; dp++) begin
                    logic ex;
                    bus_phase = 3'(bp);
                    pio_data = 8'((cp << 5) | (bp << 2) | dp);
                    step(0, 1, XF | 16'(cp << 4) | 16'(dp));
                    ex = (cp == bp) && (dp == int'(cnt_m[1:0]));
                    step(1, 0, 0);
                    chk("R7 match", pio_tx, ex);
                    chk("R8 self clear", cmd_q[7], !ex);
                    if (ex) chk("R8 sweep byte", pio_byte, pio_data);
                    chk("R3 sweep count", dstat_cnt, cnt_m);
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule